// File: doc/BRIEF.md
# DMA Interrupt Status Aggregator

This block holds the interrupt status of a network DMA engine. Single-cycle event strobes from the transmit engine, the receive engine and the bus interface each set a sticky status bit. Software reads the status word and acknowledges events by writing ones to the bits it has handled. A second register of enable bits selects which status bits contribute to two summary flags, one for routine completion events and one for fault events. The two flags together drive a single registered interrupt line.

A fatal bus error also raises a halt line to both DMA engines and latches a small error-type code. The halt line and the code stay in place until software acknowledges the bus error bit. A register port with one select bit gives access to the two registers. Status is at select 0 and enables are at select 1. Read data is combinational from the select, and writes take effect at the next clock edge.

Top module: `dma_irq_status_agg`

## Requirements
- R1: After a synchronous active-low reset, the status word, the enable word, `irq`, `dma_halt` and `bus_err_type` are all zero.
- R2: A one-cycle pulse on `hw_evt[b]` sets status bit b at the next edge, and the bit stays set. The sticky bits and their events are: 0 tx done, 1 tx stopped, 2 tx buffer unavailable, 3 tx jabber timeout, 4 rx overflow, 5 tx underflow, 6 rx done, 7 rx buffer unavailable, 8 rx stopped, 9 rx watchdog timeout, 10 early tx, 13 fatal bus error, 14 early rx.
- R3: A status write (`reg_sel`=0) clears each sticky bit whose `reg_wdata` bit is 1. Bits written with 0 keep their value.
- R4: When an event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R5: Bits 12:11 of both words read as 0. Writes to them are ignored, and so are `hw_evt[12:11]`. The enable word keeps only bits 0-10, 13 and 14, so writing all ones reads back 0x67FF.
- R6: Status bit 16 (normal summary) reads as the live OR of status bits 0, 2, 6 and 14, each ANDed with its enable bit at the same position. Writes to bit 16 have no effect.
- R7: Status bit 15 (fault summary) reads as the live OR of status bits 1, 3, 4, 5, 7, 8, 9, 10 and 13, each ANDed with its enable bit. Writes to bit 15 have no effect.
- R8: `irq` equals the OR of the two summaries one clock later.
- R9: In the edge where rx done (bit 6) goes from 0 to 1, early rx (bit 14) is cleared. This clear takes precedence over an early-rx event in the same cycle. An rx done event while bit 6 is already set leaves bit 14 alone.
- R10: `dma_halt` is high exactly while bit 13 is set. `bus_err_type` holds the `bus_err_code` sampled with the event that set bit 13, ignores later bus errors while the bit stays set, and reads 0 once the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_evt | input | 15 | Event strobes, one per status bit position |
| bus_err_code | input | ERR_W | Error type that comes with the bus error strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects status, 1 selects enables |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| irq | output | 1 | Registered interrupt request |
| dma_halt | output | 1 | Stop request to both DMA engines |
| bus_err_type | output | ERR_W | Captured bus error type |

## Verification
The bench targets the edge where an event and a write-1 clear meet on the same bit. A design that lets the clear win would silently lose that event. It also checks the early-rx self-clear on each of its three edges: rx done rising, rx done already set, and an early-rx pulse arriving together with rx done. A design that keys the clear on the raw strobe, or lets the set win there, leaves a stale early-rx flag or wipes a fresh one. Other checks cover the summaries when the enable word changes, the one-cycle `irq` delay, and a second bus error that must not overwrite the held error code.

// File: rtl/dma_irq_pkg.sv
// Package: bit positions and group masks shared by the status aggregator.
// Assumes a 15-bit sticky field with two summary flags above it.
package dma_irq_pkg;
    localparam int SRC_W    = 15;
    localparam int B_TXDONE = 0;
    localparam int B_TXSTOP = 1;
    localparam int B_TXBUF  = 2;
    localparam int B_JABBER = 3;
    localparam int B_RXOVF  = 4;
    localparam int B_TXUND  = 5;
    localparam int B_RXDONE = 6;
    localparam int B_RXBUF  = 7;
    localparam int B_RXSTOP = 8;
    localparam int B_RXWDT  = 9;
    localparam int B_ETX    = 10;
    localparam int B_BUSERR = 13;
    localparam int B_ERX    = 14;
    localparam int B_FAULT  = 15;
    localparam int B_NORMAL = 16;

    // routine-completion group
    localparam logic [SRC_W-1:0] NORMAL_GRP = (SRC_W'(1) << B_TXDONE) | (SRC_W'(1) << B_TXBUF)
                                            | (SRC_W'(1) << B_RXDONE) | (SRC_W'(1) << B_ERX);
    // fault group
    localparam logic [SRC_W-1:0] FAULT_GRP  = (SRC_W'(1) << B_TXSTOP) | (SRC_W'(1) << B_JABBER)
                                            | (SRC_W'(1) << B_RXOVF)  | (SRC_W'(1) << B_TXUND)
                                            | (SRC_W'(1) << B_RXBUF)  | (SRC_W'(1) << B_RXSTOP)
                                            | (SRC_W'(1) << B_RXWDT)  | (SRC_W'(1) << B_ETX)
                                            | (SRC_W'(1) << B_BUSERR);
    localparam logic [SRC_W-1:0] LIVE_BITS  = NORMAL_GRP | FAULT_GRP;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/dma_stat_bits.sv
// Sticky flag array. A bit whose KEEP bit is set gets a flop; any other bit reads 0.
// Priority per bit: hardware clear, then set, then software clear.
// Assumes all inputs are synchronous to clk.
module dma_stat_bits #(
    parameter int               W    = 15,
    parameter logic [W-1:0]     KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] sw_clr_i,
    input  logic [W-1:0] hw_clr_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (KEEP[i]) begin : g_live
            logic flag_q;
            // Update one sticky flag.
            always_ff @(posedge clk) begin
                if (!rst_n)            flag_q <= 1'b0;
                else if (hw_clr_i[i])  flag_q <= 1'b0;
                else if (set_i[i])     flag_q <= 1'b1;
                else if (sw_clr_i[i])  flag_q <= 1'b0;
            end
            assign q_o[i] = flag_q;
        end else begin : g_rsvd
            logic unused_in;
            assign unused_in = set_i[i] ^ sw_clr_i[i] ^ hw_clr_i[i];
            assign q_o[i]    = 1'b0;
        end
    end
endmodule

// File: rtl/dma_err_capture.sv
// Error-type latch. It captures the code when the fatal flag is clear and an error arrives,
// and it shows the code only while the fatal flag is set.
// Assumes fatal_q_i is the registered fatal bus error flag.
module dma_err_capture #(
    parameter int ERR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_evt_i,
    input  logic [ERR_W-1:0] err_code_i,
    input  logic             fatal_q_i,
    output logic [ERR_W-1:0] err_type_o
);
    logic [ERR_W-1:0] code_q;

    // Capture the code on the first error only.
    always_ff @(posedge clk) begin
        if (!rst_n)                       code_q <= '0;
        else if (err_evt_i && !fatal_q_i) code_q <= err_code_i;
    end

    assign err_type_o = fatal_q_i ? code_q : '0;
endmodule

// File: rtl/dma_irq_summary.sv
// Summary logic: enable-gated OR of the normal and fault groups.
// Purely combinational.
module dma_irq_summary
    import dma_irq_pkg::*;
(
    input  logic [SRC_W-1:0] stat_i,
    input  logic [SRC_W-1:0] en_i,
    output logic             normal_o,
    output logic             fault_o
);
    logic [SRC_W-1:0] gated;

    // Mask status with enables, then reduce each group.
    always_comb begin
        gated    = stat_i & en_i;
        normal_o = |(gated & NORMAL_GRP);
        fault_o  = |(gated & FAULT_GRP);
    end
endmodule

// File: rtl/dma_irq_status_agg.sv
// Top: sticky status, write-1-clear, enable word, summaries, registered irq, halt and error code.
// Assumes event strobes last one cycle each and a register port with one select bit (DATA_W >= 17).
module dma_irq_status_agg
    import dma_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ERR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [14:0]       hw_evt,
    input  logic [ERR_W-1:0]  bus_err_code,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              dma_halt,
    output logic [ERR_W-1:0]  bus_err_type
);
    localparam int PAD_W = DATA_W - SRC_W - 2;

    logic [SRC_W-1:0] stat_q;
    logic [SRC_W-1:0] en_q;
    logic [SRC_W-1:0] sw_clr;
    logic [SRC_W-1:0] hw_clr;
    logic             sum_normal;
    logic             sum_fault;
    logic             irq_q;
    logic             unused_wd;

    assign unused_wd = ^reg_wdata[DATA_W-1:SRC_W];

    // Build the software and hardware clear vectors.
    always_comb begin
        sw_clr = (reg_wr && reg_sel == SEL_STATUS) ? reg_wdata[SRC_W-1:0] : '0;
        hw_clr = '0;
        hw_clr[B_ERX] = hw_evt[B_RXDONE] && !stat_q[B_RXDONE];
    end

    dma_stat_bits #(.W(SRC_W), .KEEP(LIVE_BITS)) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (hw_evt),
        .sw_clr_i (sw_clr),
        .hw_clr_i (hw_clr),
        .q_o      (stat_q)
    );

    // Enable word: write only the positions that exist.
    always_ff @(posedge clk) begin
        if (!rst_n)                             en_q <= '0;
        else if (reg_wr && reg_sel == SEL_ENABLE) en_q <= reg_wdata[SRC_W-1:0] & LIVE_BITS;
    end

    dma_irq_summary u_sum (
        .stat_i   (stat_q),
        .en_i     (en_q),
        .normal_o (sum_normal),
        .fault_o  (sum_fault)
    );

    // Register the interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= sum_normal | sum_fault;
    end

    dma_err_capture #(.ERR_W(ERR_W)) u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_evt_i  (hw_evt[B_BUSERR]),
        .err_code_i (bus_err_code),
        .fatal_q_i  (stat_q[B_BUSERR]),
        .err_type_o (bus_err_type)
    );

    // Read mux.
    always_comb begin
        if (reg_sel == SEL_STATUS) reg_rdata = {{PAD_W{1'b0}}, sum_normal, sum_fault, stat_q};
        else                       reg_rdata = {{PAD_W{1'b0}}, 1'b0, 1'b0, en_q};
    end

    assign irq      = irq_q;
    assign dma_halt = stat_q[B_BUSERR];
endmodule

// File: rtl/dma_irq_status_agg_chk.sv
// Checker module bound to the aggregator. It observes ports and the status and enable state.
module dma_irq_status_agg_chk
    import dma_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ERR_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [14:0]       hw_evt,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic [ERR_W-1:0]  bus_err_type,
    input logic [SRC_W-1:0]  stat_q,
    input logic [SRC_W-1:0]  en_q
);
    // R2 (bit 14 excluded because of the R9 clear)
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(hw_evt & LIVE_BITS & ~(SRC_W'(1) << B_ERX)))
                  == $past(hw_evt & LIVE_BITS & ~(SRC_W'(1) << B_ERX))));

    // R3
    a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_STATUS)
        |=> ((stat_q & $past(reg_wdata[SRC_W-1:0] & ~hw_evt)) == '0));

    // R5
    a_r5_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (reg_rdata[12:11] == 2'b00));

    // R8
    a_r8_irq_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(stat_q & en_q))));

    // R9
    a_r9_erx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_evt[B_RXDONE] && !stat_q[B_RXDONE]) |=> !stat_q[B_ERX]);

    // R10
    a_r10_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[B_BUSERR] |=> (!stat_q[B_BUSERR] || $stable(bus_err_type)));
endmodule

bind dma_irq_status_agg dma_irq_status_agg_chk #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_evt       (hw_evt),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .irq          (irq),
    .bus_err_type (bus_err_type),
    .stat_q       (stat_q),
    .en_q         (en_q)
);

// File: tb/tb_dma_irq_status_agg.sv
// Directed bench: one task per scenario, each task checks its own results.
module tb_dma_irq_status_agg;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 32;
    localparam int ERR_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [14:0]       hw_evt = '0;
    logic [ERR_W-1:0]  bus_err_code = '0;
    logic              reg_wr = 1'b0;
    logic              reg_sel = 1'b0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq;
    logic              dma_halt;
    logic [ERR_W-1:0]  bus_err_type;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_status_agg #(.DATA_W(DATA_W), .ERR_W(ERR_W)) dut (
        .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .bus_err_code(bus_err_code),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .dma_halt(dma_halt), .bus_err_type(bus_err_type)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One cycle of stimulus: drive at a falling edge, release at the next falling edge.
    task automatic step(input logic wr, input logic sel, input logic [31:0] wd,
                        input logic [14:0] ev, input logic [2:0] code);
        reg_wr = wr; reg_sel = sel; reg_wdata = wd; hw_evt = ev; bus_err_code = code;
        @(negedge clk);
        reg_wr = 1'b0; hw_evt = '0; bus_err_code = '0; reg_wdata = '0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic idle(); step(1'b0, 1'b0, 32'h0, 15'h0, 3'd0); endtask

    task automatic clear_all();
        step(1'b1, 1'b0, 32'hFFFF_FFFF, 15'h0, 3'd0);
        step(1'b1, 1'b1, 32'h0, 15'h0, 3'd0);
        idle();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(1'b0, v); chk("R1 status", v, 32'h0);
        rd(1'b1, v); chk("R1 enable", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 halt", {31'b0, dma_halt}, 32'h0);
        chk("R1 errtype", {29'b0, bus_err_type}, 32'h0);
    endtask

    task automatic t_set_clear();
        logic [31:0] v;
        int bits[13] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 13, 14};
        foreach (bits[k]) begin
            step(1'b0, 1'b0, 32'h0, 15'(1) << bits[k], 3'd1);
            idle();
            rd(1'b0, v); chk("R2 sticky set", v & 32'h7FFF, 32'(1) << bits[k]);
            step(1'b1, 1'b0, 32'h0, 15'h0, 3'd0);
            rd(1'b0, v); chk("R3 write 0 keeps", v & 32'h7FFF, 32'(1) << bits[k]);
            step(1'b1, 1'b0, 32'(1) << bits[k], 15'h0, 3'd0);
            rd(1'b0, v); chk("R3 write 1 clears", v & 32'h7FFF, 32'h0);
        end
        step(1'b0, 1'b0, 32'h0, 15'h1800, 3'd0);
        rd(1'b0, v); chk("R5 reserved events ignored", v, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        step(1'b0, 1'b0, 32'h0, 15'h0008, 3'd0);
        step(1'b1, 1'b0, 32'h0000_0008, 15'h0008, 3'd0);
        rd(1'b0, v); chk("R4 set beats clear", v & 32'h7FFF, 32'h0008);
        step(1'b0, 1'b0, 32'h0, 15'h0010, 3'd0);
        step(1'b1, 1'b0, 32'h0000_0010, 15'h0020, 3'd0);
        rd(1'b0, v); chk("R4 other bit cleared", v & 32'h7FFF, 32'h0028);
        clear_all();
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        step(1'b1, 1'b1, 32'hFFFF_FFFF, 15'h0, 3'd0);
        rd(1'b1, v); chk("R5 enable mask", v, 32'h0000_67FF);
        step(1'b1, 1'b0, 32'h0000_1800, 15'h0, 3'd0);
        rd(1'b0, v); chk("R5 status reserved write", v, 32'h0);
        clear_all();
    endtask

    task automatic t_normal();
        logic [31:0] v;
        step(1'b1, 1'b1, 32'h0000_0001, 15'h0, 3'd0);
        step(1'b0, 1'b0, 32'h0, 15'h0080, 3'd0);
        rd(1'b0, v); chk("R7 masked fault no summary", v, 32'h0000_0080);
        step(1'b0, 1'b0, 32'h0, 15'h0001, 3'd0);
        rd(1'b0, v); chk("R6 normal summary", v, 32'h0001_0081);
        chk("R8 irq not yet", {31'b0, irq}, 32'h0);
        idle();
        chk("R8 irq one cycle later", {31'b0, irq}, 32'h1);
        step(1'b1, 1'b0, 32'h0001_0000, 15'h0, 3'd0);
        rd(1'b0, v); chk("R6 summary not writable", v, 32'h0001_0081);
        step(1'b1, 1'b1, 32'h0, 15'h0, 3'd0);
        rd(1'b0, v); chk("R6 enable removed", v, 32'h0000_0081);
        idle();
        chk("R8 irq drops", {31'b0, irq}, 32'h0);
        clear_all();
    endtask

    task automatic t_fault();
        logic [31:0] v;
        step(1'b1, 1'b1, 32'h0000_0200, 15'h0, 3'd0);
        step(1'b0, 1'b0, 32'h0, 15'h0200, 3'd0);
        rd(1'b0, v); chk("R7 fault summary", v, 32'h0000_8200);
        step(1'b1, 1'b0, 32'h0000_8000, 15'h0, 3'd0);
        rd(1'b0, v); chk("R7 summary not writable", v, 32'h0000_8200);
        chk("R8 irq from fault", {31'b0, irq}, 32'h1);
        step(1'b1, 1'b0, 32'h0000_0200, 15'h0, 3'd0);
        rd(1'b0, v); chk("R7 clears with source", v, 32'h0);
        idle();
        chk("R8 irq clears", {31'b0, irq}, 32'h0);
        clear_all();
    endtask

    task automatic t_early_rx();
        logic [31:0] v;
        step(1'b0, 1'b0, 32'h0, 15'h4000, 3'd0);
        step(1'b0, 1'b0, 32'h0, 15'h0040, 3'd0);
        rd(1'b0, v); chk("R9 rx done clears early rx", v, 32'h0000_0040);
        step(1'b0, 1'b0, 32'h0, 15'h4000, 3'd0);
        step(1'b0, 1'b0, 32'h0, 15'h0040, 3'd0);
        rd(1'b0, v); chk("R9 rx done already set", v, 32'h0000_4040);
        clear_all();
        step(1'b0, 1'b0, 32'h0, 15'h4040, 3'd0);
        rd(1'b0, v); chk("R9 same-cycle pulse", v, 32'h0000_0040);
        clear_all();
    endtask

    task automatic t_bus_err();
        logic [31:0] v;
        step(1'b0, 1'b0, 32'h0, 15'h2000, 3'd5);
        chk("R10 halt", {31'b0, dma_halt}, 32'h1);
        chk("R10 code", {29'b0, bus_err_type}, 32'h5);
        step(1'b0, 1'b0, 32'h0, 15'h2000, 3'd2);
        chk("R10 code held", {29'b0, bus_err_type}, 32'h5);
        step(1'b1, 1'b0, 32'h0000_2000, 15'h0, 3'd0);
        chk("R10 halt off", {31'b0, dma_halt}, 32'h0);
        chk("R10 code zero", {29'b0, bus_err_type}, 32'h0);
        step(1'b0, 1'b0, 32'h0, 15'h2000, 3'd2);
        chk("R10 new code", {29'b0, bus_err_type}, 32'h2);
        rd(1'b0, v); chk("R10 status bit", v, 32'h0000_2000);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_set_wins();
        t_reserved();
        t_normal();
        t_fault();
        t_early_rx();
        t_bus_err();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule